// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer and Data Mask Path

This block sits on the data side of a synchronous DRAM device, between the decoded command logic and the storage array. It takes a read or write strobe with a starting column and turns it into one array column access per clock for the whole burst. It can form the column sequence in linear order, wrapping inside the burst, or in interleaved order. It also gates each beat with the byte mask. Write data is masked in the cycle it is presented. For reads, the mask input suppresses the output drivers two cycles after it is sampled. Read data reaches the device pins after a programmed CAS latency of two or three clocks.

A command sampled while a burst is running cancels the rest of that burst. The new burst starts in the same cycle. When the command asked for automatic deactivation and its burst runs to the end, the block raises a one-cycle precharge request to the bank logic. The array itself is outside this block. It must return `arr_rdata` for the `arr_addr` presented in the same cycle, which is an asynchronous read.

Top module: `sdram_burst_dp`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `arr_rd`, `arr_wr`, `pre_req` and `dq_oe` are 0 and `dq_out` is 0.
- R2: A command sampled in cycle c issues beat k of its burst in cycle c+k. Each beat raises `arr_rd` (read) or is eligible for `arr_wr` (write) in cycle c+k+1. The burst length is 2^`bl_code` beats: code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 8.
- R3: With `burst_ilv`=0, beat k addresses the start column with its low log2(length) bits replaced by (those bits + k) mod length. The upper bits are unchanged.
- R4: With `burst_ilv`=1, beat k addresses the start column XOR k.
- R5: For a write beat in cycle c, `arr_wr` is 1 in cycle c+1 only if `dqm` was 0 in cycle c. `arr_wdata` in c+1 equals `wdata` from cycle c.
- R6: A read beat issued in cycle c drives the array word of its column on `dq_out` with `dq_oe`=1 in cycle c+2 when `cas_lat3`=0, or in cycle c+3 when `cas_lat3`=1, unless R7 masks it.
- R7: `dqm`=1 in cycle m forces `dq_oe`=0 and `dq_out`=0 in cycle m+2.
- R8: In any cycle where no read beat is due on the pins, `dq_oe`=0 and `dq_out`=0.
- R9: A command sampled while a burst is in progress ends that burst at once. The new burst's beat 0 is issued in the same cycle.
- R10: When a burst that was started with `auto_pre`=1 issues its last beat without being cut short, `pre_req` is 1 for one cycle, in the cycle that carries that beat's array enable. Otherwise `pre_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_cmd | input | 1 | Decoded read command strobe |
| wr_cmd | input | 1 | Decoded write command strobe |
| auto_pre | input | 1 | Request bank precharge at burst end |
| start_col | input | COL_W | Starting column of the burst |
| bl_code | input | 2 | Burst length code (length = 2^code) |
| burst_ilv | input | 1 | 0 = linear wrapped order, 1 = interleaved order |
| cas_lat3 | input | 1 | 0 = CAS latency 2, 1 = CAS latency 3 |
| dqm | input | 1 | Byte mask: write mask now, read driver mask two cycles on |
| wdata | input | DW | Write data for the current beat |
| arr_rdata | input | DW | Array read data for `arr_addr`, same cycle |
| arr_addr | output | COL_W | Array column address |
| arr_rd | output | 1 | Array read enable |
| arr_wr | output | 1 | Array write enable |
| arr_wdata | output | DW | Array write data |
| dq_out | output | DW | Data toward the pins |
| dq_oe | output | 1 | Output driver enable (0 = high impedance) |
| pre_req | output | 1 | One-cycle bank precharge request |

## Verification
The embedded properties assume three things about the inputs. Read and write strobes are never asserted together. `cas_lat3` changes only while no read data is in flight. The array answers in the same cycle as the address. The stimulus picks at most one command kind per cycle. It switches CAS latency only after a run of idle cycles that drains the read pipeline. It models the array as a fixed function of the column, so every read beat has a known value. Random command gaps often land inside running bursts, so termination and mask timing are exercised against every burst length and both orders.

// File: rtl/sdram_dp_pkg.sv
package sdram_dp_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;

  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } burst_dir_e;
endpackage

// File: rtl/sdp_burst_seq.sv
module sdp_burst_seq
  import sdram_dp_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BEAT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_cmd,
  input  logic             wr_cmd,
  input  logic             auto_pre,
  input  logic [COL_W-1:0] start_col,
  input  logic [1:0]       bl_code,
  input  logic             burst_ilv,
  output logic             iss,
  output logic             iss_wr,
  output logic [COL_W-1:0] iss_addr,
  output logic             iss_last,
  output logic             iss_ap
);
  logic              act_q;
  logic [BEAT_W-1:0] cnt_q, msk_q;
  logic [COL_W-1:0]  base_q;
  burst_order_e      ord_q;
  burst_dir_e        dir_q;
  logic              ap_q;

  logic              cmd;
  logic [BEAT_W-1:0] cur_cnt, cur_msk, low, off;
  logic [COL_W-1:0]  cur_base;
  burst_order_e      cur_ord;
  burst_dir_e        cur_dir;

  always_comb begin
    cmd      = rd_cmd | wr_cmd;
    cur_base = cmd ? start_col : base_q;
    cur_msk  = cmd ? BEAT_W'((32'd1 << bl_code) - 32'd1) : msk_q;
    cur_cnt  = cmd ? '0 : cnt_q;
    cur_ord  = cmd ? burst_order_e'(burst_ilv) : ord_q;
    cur_dir  = cmd ? (rd_cmd ? DIR_READ : DIR_WRITE) : dir_q;
    iss_ap   = cmd ? auto_pre : ap_q;
    iss      = cmd | act_q;
    low      = cur_base[BEAT_W-1:0];
    if (cur_ord == ORD_XOR) off = low ^ cur_cnt;
    else                    off = (low & ~cur_msk) | ((low + cur_cnt) & cur_msk);
    iss_addr = {cur_base[COL_W-1:BEAT_W], off};
    iss_wr   = (cur_dir == DIR_WRITE);
    iss_last = iss && (cur_cnt == cur_msk);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      msk_q  <= '0;
      base_q <= '0;
      ord_q  <= ORD_LINEAR;
      dir_q  <= DIR_READ;
      ap_q   <= 1'b0;
    end else if (iss) begin
      act_q  <= !iss_last;
      cnt_q  <= cur_cnt + 1'b1;
      msk_q  <= cur_msk;
      base_q <= cur_base;
      ord_q  <= cur_ord;
      dir_q  <= cur_dir;
      ap_q   <= iss_ap;
    end
  end

  // R2
  beat_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    act_q |-> ((cnt_q != '0) && ((cnt_q & ~msk_q) == '0)));

  // R9
  cmd_restarts_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_cmd || wr_cmd) |=> (act_q == (msk_q != '0)));
endmodule

// File: rtl/sdp_arr_stage.sv
module sdp_arr_stage #(
  parameter int COL_W = 9,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iss,
  input  logic             iss_wr,
  input  logic [COL_W-1:0] iss_addr,
  input  logic             iss_last,
  input  logic             iss_ap,
  input  logic             dqm,
  input  logic [DW-1:0]    wdata,
  output logic [COL_W-1:0] arr_addr,
  output logic             arr_rd,
  output logic             arr_wr,
  output logic [DW-1:0]    arr_wdata,
  output logic             pre_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      arr_addr  <= '0;
      arr_rd    <= 1'b0;
      arr_wr    <= 1'b0;
      arr_wdata <= '0;
      pre_req   <= 1'b0;
    end else begin
      arr_rd  <= iss && !iss_wr;
      arr_wr  <= iss && iss_wr && !dqm;
      pre_req <= iss_last && iss_ap;
      if (iss) arr_addr <= iss_addr;
      if (iss && iss_wr) arr_wdata <= wdata;
    end
  end

  // R5
  wr_mask_chk: assert property (@(posedge clk) disable iff (rst)
    arr_wr |-> !$past(dqm));

  // R10
  pre_with_beat_chk: assert property (@(posedge clk) disable iff (rst)
    pre_req |-> (arr_rd || arr_wr || $past(dqm)));

  // R2
  one_dir_chk: assert property (@(posedge clk) disable iff (rst)
    !(arr_rd && arr_wr));
endmodule

// File: rtl/sdp_rd_pipe.sv
module sdp_rd_pipe #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cas_lat3,
  input  logic          dqm,
  input  logic          rd_vld,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);
  logic          dqm_d1;
  logic          p2_vld;
  logic [DW-1:0] p2_data;
  logic          sel_vld, drive;
  logic [DW-1:0] sel_data;

  always_comb begin
    sel_vld  = cas_lat3 ? p2_vld  : rd_vld;
    sel_data = cas_lat3 ? p2_data : rd_data;
    drive    = sel_vld && !dqm_d1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dqm_d1  <= 1'b0;
      p2_vld  <= 1'b0;
      p2_data <= '0;
      dq_oe   <= 1'b0;
      dq_out  <= '0;
    end else begin
      dqm_d1  <= dqm;
      p2_vld  <= rd_vld;
      p2_data <= rd_data;
      dq_oe   <= drive;
      dq_out  <= drive ? sel_data : '0;
    end
  end

  // R7
  rd_mask_chk: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> !$past(dqm, 2));

  // R8
  oe_has_beat_chk: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (cas_lat3 ? $past(rd_vld, 2) : $past(rd_vld)));

  // R8
  hiz_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !dq_oe |-> (dq_out == '0));
endmodule

// File: rtl/sdram_burst_dp.sv
module sdram_burst_dp #(
  parameter int COL_W  = 9,
  parameter int DW     = 8,
  parameter int MAX_BL = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_cmd,
  input  logic             wr_cmd,
  input  logic             auto_pre,
  input  logic [COL_W-1:0] start_col,
  input  logic [1:0]       bl_code,
  input  logic             burst_ilv,
  input  logic             cas_lat3,
  input  logic             dqm,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    arr_rdata,
  output logic [COL_W-1:0] arr_addr,
  output logic             arr_rd,
  output logic             arr_wr,
  output logic [DW-1:0]    arr_wdata,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe,
  output logic             pre_req
);
  localparam int BEAT_W = $clog2(MAX_BL);

  logic             iss, iss_wr, iss_last, iss_ap;
  logic [COL_W-1:0] iss_addr;

  sdp_burst_seq #(.COL_W(COL_W), .BEAT_W(BEAT_W)) seq_i (
    .clk(clk), .rst(rst), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
    .auto_pre(auto_pre), .start_col(start_col), .bl_code(bl_code),
    .burst_ilv(burst_ilv), .iss(iss), .iss_wr(iss_wr),
    .iss_addr(iss_addr), .iss_last(iss_last), .iss_ap(iss_ap)
  );

  sdp_arr_stage #(.COL_W(COL_W), .DW(DW)) arr_i (
    .clk(clk), .rst(rst), .iss(iss), .iss_wr(iss_wr),
    .iss_addr(iss_addr), .iss_last(iss_last), .iss_ap(iss_ap),
    .dqm(dqm), .wdata(wdata), .arr_addr(arr_addr), .arr_rd(arr_rd),
    .arr_wr(arr_wr), .arr_wdata(arr_wdata), .pre_req(pre_req)
  );

  sdp_rd_pipe #(.DW(DW)) rdp_i (
    .clk(clk), .rst(rst), .cas_lat3(cas_lat3), .dqm(dqm),
    .rd_vld(arr_rd), .rd_data(arr_rdata), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // R2 (input assumption: one command kind per cycle)
  single_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_cmd && wr_cmd));
endmodule

// File: tb/sdram_burst_dp_tb_top.sv
module sdram_burst_dp_tb_top;
  localparam int COL_W = 9;
  localparam int DW    = 8;
  localparam int HN    = 8192;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst, rd_cmd, wr_cmd, auto_pre, burst_ilv, cas_lat3, dqm;
  logic [COL_W-1:0] start_col;
  logic [1:0]       bl_code;
  logic [DW-1:0]    wdata, arr_rdata, arr_wdata, dq_out;
  logic [COL_W-1:0] arr_addr;
  logic             arr_rd, arr_wr, dq_oe, pre_req;

  function automatic logic [DW-1:0] pat(logic [COL_W-1:0] a);
    return a[7:0] ^ {a[8], a[8], 6'h2D};
  endfunction

  assign arr_rdata = pat(arr_addr);

  sdram_burst_dp dut_i (
    .clk(clk), .rst(rst), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
    .auto_pre(auto_pre), .start_col(start_col), .bl_code(bl_code),
    .burst_ilv(burst_ilv), .cas_lat3(cas_lat3), .dqm(dqm), .wdata(wdata),
    .arr_rdata(arr_rdata), .arr_addr(arr_addr), .arr_rd(arr_rd),
    .arr_wr(arr_wr), .arr_wdata(arr_wdata), .dq_out(dq_out),
    .dq_oe(dq_oe), .pre_req(pre_req)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 0;

  // reference model state
  bit m_act = 0, m_ilv = 0, m_wr = 0, m_ap = 0, m_irq = 0;
  int m_cnt = 0, m_len = 1, m_start = 0;
  bit e_rd = 0, e_wr = 0, e_pre = 0;
  int e_addr = 0, e_wd = 0;
  string e_atag = "R3", e_wtag = "R2";
  bit h_rd [HN];
  int h_addr [HN];
  bit h_dqm [HN];

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  function automatic int exp_addr(int st, int len, bit ilv, int k);
    int msk = len - 1;
    if (ilv) return st ^ k;
    return (st & ~msk) | ((st + k) & msk);
  endfunction

  task automatic step(bit rd, bit wr, bit ap, int col, int bl, bit ilv, bit dq, int wd);
    int clv, t;
    bit rdok, mk, x_oe, last;
    int x_out, a;
    string tg;
    @(negedge clk);
    // outputs of cycle cyc
    chk(arr_rd == e_rd, e_wtag, int'(arr_rd), int'(e_rd));
    chk(arr_wr == e_wr, e_wtag, int'(arr_wr), int'(e_wr));
    if (e_rd || e_wr) chk(int'(arr_addr) == e_addr, e_atag, int'(arr_addr), e_addr);
    if (e_wr) chk(int'(arr_wdata) == e_wd, "R5", int'(arr_wdata), e_wd);
    chk(pre_req == e_pre, "R10", int'(pre_req), int'(e_pre));
    clv  = cas_lat3 ? 3 : 2;
    t    = cyc;
    rdok = (t - clv >= 0) && h_rd[(t - clv) % HN];
    mk   = (t >= 2) && h_dqm[(t - 2) % HN];
    x_oe = rdok && !mk;
    x_out = x_oe ? int'(pat(COL_W'(h_addr[(t - clv) % HN]))) : 0;
    tg = !rdok ? "R8" : (mk ? "R7" : "R6");
    chk(dq_oe == x_oe, tg, int'(dq_oe), int'(x_oe));
    chk(int'(dq_out) == x_out, tg, int'(dq_out), x_out);
    // drive cycle cyc
    rd_cmd = rd; wr_cmd = wr; auto_pre = ap; start_col = COL_W'(col);
    bl_code = 2'(bl); burst_ilv = ilv; dqm = dq; wdata = DW'(wd);
    if (rd || wr) begin
      m_irq = m_act; m_act = 1; m_cnt = 0; m_len = 1 << bl;
      m_start = col; m_ilv = ilv; m_wr = wr; m_ap = ap;
    end
    h_dqm[cyc % HN] = dq;
    if (m_act) begin
      a = exp_addr(m_start, m_len, m_ilv, m_cnt);
      last = (m_cnt == m_len - 1);
      e_rd = !m_wr; e_wr = m_wr && !dq; e_addr = a; e_wd = wd;
      e_pre = last && m_ap;
      e_atag = m_irq ? "R9" : (m_ilv ? "R4" : "R3");
      e_wtag = (m_wr && dq) ? "R5" : "R2";
      h_rd[cyc % HN] = !m_wr; h_addr[cyc % HN] = a;
      m_cnt++;
      if (last) m_act = 0;
    end else begin
      e_rd = 0; e_wr = 0; e_pre = 0; e_wtag = "R2";
      h_rd[cyc % HN] = 0; h_addr[cyc % HN] = 0;
    end
    cyc++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=running expected=finished");
      report();
    end
  end

  initial begin
    int r;
    r = $urandom(32'd4242);
    rst = 1; rd_cmd = 0; wr_cmd = 0; auto_pre = 0; start_col = '0;
    bl_code = '0; burst_ilv = 0; cas_lat3 = 0; dqm = 0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(!arr_rd && !arr_wr && !pre_req, "R1", int'({arr_rd, arr_wr, pre_req}), 0);
    chk(!dq_oe && dq_out == '0, "R1", int'(dq_out), 0);
    rst = 0;
    idle(2);
    for (int c = 0; c < 2; c++) begin
      cas_lat3 = c[0];
      // R2 R3 R4 R6 R10: every length and order, reads with auto precharge
      for (int bl = 0; bl < 4; bl++)
        for (int o = 0; o < 2; o++) begin
          step(1, 0, 1, 9'h0A7 + bl * 16 + o, bl, o[0], 0, 0);
          idle((1 << bl) + 4);
        end
      // R3 R4 wrap corner: low bits all ones
      step(1, 0, 0, 9'h1FF, 3, 0, 0, 0); idle(11);
      step(1, 0, 0, 9'h1FF, 3, 1, 0, 0); idle(11);
      // R5 write with alternating mask, auto precharge
      step(0, 1, 1, 9'h040, 3, 0, 0, 8'h11);
      for (int k = 1; k < 8; k++) step(0, 0, 0, 0, 0, 0, k[0], 8'h11 + k);
      idle(4);
      // R7 read with masked beats
      step(1, 0, 0, 9'h123, 3, 0, 1, 0);
      for (int k = 1; k < 8; k++) step(0, 0, 0, 0, 0, 0, (k % 3) == 0, 0);
      idle(6);
      // R9 interrupt: read cut by write, then by read; no precharge on cut burst
      step(1, 0, 1, 9'h010, 3, 0, 0, 0);
      idle(2);
      step(0, 1, 0, 9'h0F3, 2, 1, 0, 8'hA5);
      step(1, 0, 1, 9'h155, 1, 0, 0, 0);
      idle(8);
      // random phase
      for (int i = 0; i < 700; i++) begin
        bit go, w;
        go = ($urandom % 4) == 0;
        w  = $urandom % 2;
        step(go && !w, go && w, $urandom % 2, $urandom % 512, $urandom % 4,
             $urandom % 2, ($urandom % 4) == 0, $urandom % 256);
      end
      idle(12);
    end
    done = 1;
    report();
  end
endmodule